// File: doc/BRIEF.md
# Floating-Point Class Test Unit

This block decides whether a double-precision operand belongs to a set of value classes and records the verdict as a complementary pair of predicate bits. The set is a 9-bit mask. Each bit names one class: a sign (positive or negative), a kind of finite or infinite value (zero, un-normalized, normalized, infinity), a flavour of NaN (quiet or signaling), or the special not-a-thing tag that a separate input bit carries beside the operand. Subnormal encodings fall in the un-normalized class.

A match is the OR of three terms. The first is a tagged value with the tag bit of the mask set. The second is a NaN whose own flavour bit is set. The third is an ordinary value whose sign bit in the mask is set and whose kind bit in the mask is also set. The sense input may invert the match. The result and its complement go to two named entries of a predicate register file on the next clock edge, under control of a qualifying predicate and a normal or unconditional mode. Entry 0 of the file is hard-wired to one. It may be named as a target, and any write to it is lost.

Top module: `fpclass_pred_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released, `pred_all` is 0 in every entry except entry 0, which is 1.
- R2: `pred_all[0]` is always 1. A write aimed at index 0 has no effect, and the other target of the same operation is still written.
- R3: An operand that is not NaN and not tagged matches when two mask bits are both set. The sign bit is bit 0 (positive) or bit 1 (negative), chosen by bit 63 of the operand. The kind bit is bit 2 (zero), bit 3 (exponent zero with a nonzero fraction), bit 4 (normalized) or bit 5 (infinity). A zero test therefore needs bit 2 together with the sign bits.
- R4: An operand with an all-ones exponent and a nonzero fraction is a NaN. It is quiet when fraction bit 51 is 1 and matches through mask bit 7; otherwise it is signaling and matches through mask bit 6. A NaN never matches through bits 0 to 5.
- R5: When `op_nat` is 1, the operand matches if and only if mask bit 8 is set, whatever its 64 encoding bits hold.
- R6: The mask 0x1FF matches every operand, tagged or not.
- R7: With `sense_not`=0 and `qual_pred`=1, entry `dst_first` receives the match and entry `dst_second` its complement. With `sense_not`=1 both values are inverted.
- R8: With `unc_mode`=0 and `qual_pred`=0, an operation leaves every entry unchanged.
- R9: With `unc_mode`=1 and `qual_pred`=0, both target entries are written 0.
- R10: A write is visible on `pred_all` just after the rising edge that samples `op_valid`=1 and not before it.
- R11: When `dst_first` equals `dst_second`, that entry takes the value meant for the second target.
- R12: In a cycle with `op_valid`=0, no entry changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_value | input | 64 | IEEE double operand |
| op_nat | input | 1 | Operand carries the not-a-thing tag |
| class_mask | input | 9 | Classes sought, one bit per class |
| sense_not | input | 1 | 0 tests membership, 1 tests non-membership |
| unc_mode | input | 1 | 1 selects unconditional mode |
| qual_pred | input | 1 | Qualifying predicate of the operation |
| dst_first | input | 6 | Index written with the result |
| dst_second | input | 6 | Index written with the complement |
| pred_all | output | 64 | Current contents of the predicate file |

## Verification
Two writes can land in the same cycle. One case is both targets naming the same entry. The other is one target naming the fixed entry 0 while the other names a real entry. The bench provokes both cases with directed operations. It also lets random destination indices drawn from a small range collide by themselves. After each edge it compares the whole predicate vector against a model in which the second target wins a collision and index 0 stays 1. The unconditional clear with a false qualifying predicate is judged the same way when both of its targets collide.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

   localparam int MASK_W  = 9;
   localparam int MB_POS  = 0;
   localparam int MB_NEG  = 1;
   localparam int MB_ZERO = 2;
   localparam int MB_SUB  = 3;
   localparam int MB_NORM = 4;
   localparam int MB_INF  = 5;
   localparam int MB_SNAN = 6;
   localparam int MB_QNAN = 7;
   localparam int MB_NAT  = 8;

   typedef struct packed {
      logic nat;
      logic qnan;
      logic snan;
      logic inf;
      logic norm;
      logic sub;
      logic zero;
      logic neg;
   } fpc_class_t;

endpackage

// File: rtl/fpc_classify.sv
module fpc_classify
   import fpc_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   localparam int VAL_W = EXP_W + MAN_W + 1
) (
   input  logic [VAL_W-1:0] value,
   input  logic             nat,
   output fpc_class_t       cls
);

   logic [EXP_W-1:0] exp_f;
   logic [MAN_W-1:0] man_f;
   logic             exp_max;
   logic             exp_min;
   logic             man_nz;

   assign exp_f   = value[VAL_W-2 -: EXP_W];
   assign man_f   = value[MAN_W-1:0];
   assign exp_max = &exp_f;
   assign exp_min = ~|exp_f;
   assign man_nz  = |man_f;

   // the tag overrides every encoding-derived class
   always_comb begin
      cls      = '0;
      cls.nat  = nat;
      cls.neg  = value[VAL_W-1];
      if (!nat) begin
         cls.qnan = exp_max &  man_nz &  man_f[MAN_W-1];
         cls.snan = exp_max &  man_nz & ~man_f[MAN_W-1];
         cls.inf  = exp_max & ~man_nz;
         cls.zero = exp_min & ~man_nz;
         cls.sub  = exp_min &  man_nz;
         cls.norm = ~exp_max & ~exp_min;
      end
   end

endmodule

// File: rtl/fpc_match.sv
module fpc_match
   import fpc_pkg::*;
(
   input  fpc_class_t        cls,
   input  logic [MASK_W-1:0] mask,
   output logic              hit
);

   logic nat_term;
   logic nan_term;
   logic sign_ok;
   logic kind_ok;
   logic ord_term;

   assign nat_term = cls.nat & mask[MB_NAT];
   assign nan_term = (cls.qnan & mask[MB_QNAN]) | (cls.snan & mask[MB_SNAN]);
   assign sign_ok  = cls.neg ? mask[MB_NEG] : mask[MB_POS];
   assign kind_ok  = (cls.zero & mask[MB_ZERO]) | (cls.sub  & mask[MB_SUB])
                   | (cls.norm & mask[MB_NORM]) | (cls.inf  & mask[MB_INF]);
   assign ord_term = sign_ok & kind_ok;
   assign hit      = nat_term | nan_term | ord_term;

endmodule

// File: rtl/fpc_pred_file.sv
module fpc_pred_file #(
   parameter int NPRED = 64,
   localparam int IDX_W = $clog2(NPRED)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [IDX_W-1:0] idx_a,
   input  logic             d_a,
   input  logic [IDX_W-1:0] idx_b,
   input  logic             d_b,
   output logic [NPRED-1:0] q
);

   generate
      for (genvar g = 0; g < NPRED; g++) begin : g_ent
         if (g == 0) begin : g_fixed
            assign q[g] = 1'b1;
         end else begin : g_reg
            logic hit_a;
            logic hit_b;
            assign hit_a = we && (idx_a == IDX_W'(g));
            assign hit_b = we && (idx_b == IDX_W'(g));
            // the second target takes priority on a collision
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)     q[g] <= 1'b0;
               else if (hit_b) q[g] <= d_b;
               else if (hit_a) q[g] <= d_a;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fpclass_pred_unit.sv
module fpclass_pred_unit
   import fpc_pkg::*;
#(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int NPRED = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       op_valid,
   input  logic [EXP_W+MAN_W:0]       op_value,
   input  logic                       op_nat,
   input  logic [8:0]                 class_mask,
   input  logic                       sense_not,
   input  logic                       unc_mode,
   input  logic                       qual_pred,
   input  logic [$clog2(NPRED)-1:0]   dst_first,
   input  logic [$clog2(NPRED)-1:0]   dst_second,
   output logic [NPRED-1:0]           pred_all
);

   localparam int IDX_W = $clog2(NPRED);

   generate
      if (NPRED < 2 || (NPRED & (NPRED - 1)) != 0) begin : g_bad_npred
         $error("NPRED must be a power of two of at least 2");
      end
      if (EXP_W < 2 || MAN_W < 2) begin : g_bad_fmt
         $error("EXP_W and MAN_W must each be at least 2");
      end
   endgenerate

   fpc_class_t cls;
   logic       hit;
   logic       res;
   logic       wr_en;
   logic       d_first;
   logic       d_second;

   fpc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_classify (
      .value (op_value),
      .nat   (op_nat),
      .cls   (cls)
   );

   fpc_match u_match (
      .cls  (cls),
      .mask (class_mask),
      .hit  (hit)
   );

   assign res      = hit ^ sense_not;
   assign wr_en    = op_valid & (qual_pred | unc_mode);
   assign d_first  = qual_pred &  res;
   assign d_second = qual_pred & ~res;

   fpc_pred_file #(.NPRED(NPRED)) u_file (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (wr_en),
      .idx_a (dst_first),
      .d_a   (d_first),
      .idx_b (dst_second),
      .d_b   (d_second),
      .q     (pred_all)
   );

endmodule

// File: rtl/fpclass_pred_chk.sv
module fpclass_pred_chk #(
   parameter int EXP_W = 11,
   parameter int MAN_W = 52,
   parameter int NPRED = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     op_valid,
   input logic [EXP_W+MAN_W:0]     op_value,
   input logic                     op_nat,
   input logic [8:0]               class_mask,
   input logic                     sense_not,
   input logic                     unc_mode,
   input logic                     qual_pred,
   input logic [$clog2(NPRED)-1:0] dst_first,
   input logic [$clog2(NPRED)-1:0] dst_second,
   input logic [NPRED-1:0]         pred_all
);

   always_comb begin
      if (rst_n) begin
         AST_ENTRY0_SET: assert (pred_all[0] == 1'b1); // R2
      end
   end

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(pred_all)); // R12

   AST_NORMAL_FALSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !qual_pred && !unc_mode) |=> $stable(pred_all)); // R8

   AST_UNC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && !qual_pred && unc_mode && dst_second != '0)
      |=> pred_all[$past(dst_second)] == 1'b0); // R9

   AST_PAIR_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && qual_pred && dst_first != '0 && dst_second != '0
       && dst_first != dst_second)
      |=> pred_all[$past(dst_first)] != pred_all[$past(dst_second)]); // R7

   AST_NAT_BY_TAG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && qual_pred && op_nat && !sense_not && dst_first != '0
       && dst_first != dst_second)
      |=> pred_all[$past(dst_first)] == $past(class_mask[8])); // R5

   AST_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (op_valid && qual_pred && class_mask == 9'h1FF && !sense_not
       && dst_first != '0 && dst_first != dst_second)
      |=> pred_all[$past(dst_first)] == 1'b1); // R6

endmodule

bind fpclass_pred_unit fpclass_pred_chk #(
   .EXP_W(EXP_W), .MAN_W(MAN_W), .NPRED(NPRED)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_value   (op_value),
   .op_nat     (op_nat),
   .class_mask (class_mask),
   .sense_not  (sense_not),
   .unc_mode   (unc_mode),
   .qual_pred  (qual_pred),
   .dst_first  (dst_first),
   .dst_second (dst_second),
   .pred_all   (pred_all)
);

// File: tb/fpclass_pred_unit_test.sv
`timescale 1ns/1ps
module fpclass_pred_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [63:0] op_value = '0;
   logic        op_nat = 1'b0;
   logic [8:0]  class_mask = '0;
   logic        sense_not = 1'b0;
   logic        unc_mode = 1'b0;
   logic        qual_pred = 1'b0;
   logic [5:0]  dst_first = '0;
   logic [5:0]  dst_second = '0;
   logic [63:0] pred_all;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [63:0] model;

   always #4 clk = ~clk;

   fpclass_pred_unit uut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_value(op_value),
      .op_nat(op_nat), .class_mask(class_mask), .sense_not(sense_not),
      .unc_mode(unc_mode), .qual_pred(qual_pred), .dst_first(dst_first),
      .dst_second(dst_second), .pred_all(pred_all)
   );

   function automatic bit ref_match(logic [63:0] v, logic nat, logic [8:0] m);
      logic [10:0] e;
      logic [51:0] f;
      logic        s, k;
      e = v[62:52];
      f = v[51:0];
      if (nat) return m[8];
      if (e == 11'h7FF && f != 0) return f[51] ? m[7] : m[6];
      s = v[63] ? m[1] : m[0];
      if (e == 11'h7FF)            k = m[5];
      else if (e == 0 && f == 0)   k = m[2];
      else if (e == 0)             k = m[3];
      else                         k = m[4];
      return s & k;
   endfunction

   // kind: 0 zero, 1 subnormal, 2 normal, 3 inf, 4 qnan, 5 snan
   function automatic logic [63:0] make_val(int kind, logic sgn, logic [63:0] rnd);
      logic [51:0] f;
      logic [10:0] e;
      f = rnd[51:0];
      e = rnd[62:52];
      case (kind)
         0: return {sgn, 11'h000, 52'h0};
         1: return {sgn, 11'h000, (f == 0) ? 52'h1 : f};
         2: return {sgn, (e == 0 || e == 11'h7FF) ? 11'h3FF : e, f};
         3: return {sgn, 11'h7FF, 52'h0};
         4: return {sgn, 11'h7FF, 1'b1, f[50:0]};
         default: return {sgn, 11'h7FF, 1'b0, (f[50:0] == 0) ? 51'h1 : f[50:0]};
      endcase
   endfunction

   task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic run_op(logic [63:0] v, logic nat, logic [8:0] m, logic sn,
                         logic unc, logic qp, logic [5:0] a, logic [5:0] b,
                         string tag);
      bit r;
      @(negedge clk);
      op_valid = 1'b1; op_value = v; op_nat = nat; class_mask = m;
      sense_not = sn; unc_mode = unc; qual_pred = qp;
      dst_first = a; dst_second = b;
      #1;
      check(pred_all === model, "R10 pre-edge", pred_all, model);
      if (qp) begin
         r = ref_match(v, nat, m) ^ sn;
         model[a] = r;
         model[b] = ~r;
      end else if (unc) begin
         model[a] = 1'b0;
         model[b] = 1'b0;
      end
      model[0] = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      check(pred_all === model, tag, pred_all, model);
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=done");
         finish_run();
      end
   end

   initial begin
      void'($urandom(32'h5EED_0C1A));
      model = 64'h1;
      #2;
      check(pred_all === 64'h1, "R1 during reset", pred_all, 64'h1);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(pred_all === 64'h1, "R1 after reset", pred_all, 64'h1);

      // zero test, sign-and-kind rule (R3)
      run_op(make_val(0,0,0), 0, 9'h004, 0, 0, 1, 6'd1, 6'd2, "R3 +0 zero-only");
      run_op(make_val(0,1,0), 0, 9'h005, 0, 0, 1, 6'd3, 6'd4, "R3 -0 pos-zero");
      run_op(make_val(0,1,0), 0, 9'h007, 0, 0, 1, 6'd5, 6'd6, "R3 -0 both signs");
      run_op(make_val(1,0,64'h5), 0, 9'h009, 0, 0, 1, 6'd7, 6'd8, "R3 subnormal");
      run_op(make_val(3,1,0), 0, 9'h022, 0, 0, 1, 6'd9, 6'd10, "R3 -inf");
      // NaN kinds (R4)
      run_op(make_val(4,0,64'h9), 0, 9'h03F, 0, 0, 1, 6'd11, 6'd12, "R4 qnan via sign/kind");
      run_op(make_val(4,0,64'h9), 0, 9'h080, 0, 0, 1, 6'd13, 6'd14, "R4 qnan bit");
      run_op(make_val(5,1,64'h3), 0, 9'h080, 0, 0, 1, 6'd15, 6'd16, "R4 snan not quiet");
      run_op(make_val(5,1,64'h3), 0, 9'h040, 0, 0, 1, 6'd17, 6'd18, "R4 snan bit");
      // tag (R5)
      run_op(make_val(2,0,64'h123), 1, 9'h0FF, 0, 0, 1, 6'd19, 6'd20, "R5 tag without bit");
      run_op(make_val(4,0,64'h7), 1, 9'h100, 0, 0, 1, 6'd21, 6'd22, "R5 tag bit");
      // full mask and inversion (R6, R7)
      run_op(make_val(5,0,64'h1), 0, 9'h1FF, 0, 0, 1, 6'd23, 6'd24, "R6 full mask snan");
      run_op(make_val(2,1,64'hABC), 0, 9'h1FF, 1, 0, 1, 6'd25, 6'd26, "R7 not-member");
      // predication (R8, R9)
      run_op(make_val(2,0,0), 0, 9'h1FF, 0, 0, 0, 6'd1, 6'd4, "R8 normal false");
      run_op(make_val(2,0,0), 0, 9'h1FF, 0, 1, 0, 6'd5, 6'd7, "R9 unc false");
      // same-cycle collisions (R2, R11)
      run_op(make_val(2,0,0), 0, 9'h011, 0, 0, 1, 6'd0, 6'd30, "R2 first at 0");
      run_op(make_val(2,0,0), 0, 9'h000, 0, 0, 1, 6'd31, 6'd0, "R2 second at 0");
      run_op(make_val(2,0,0), 0, 9'h011, 0, 0, 1, 6'd40, 6'd40, "R11 same index");
      run_op(make_val(2,0,0), 0, 9'h000, 1, 0, 1, 6'd41, 6'd41, "R11 same index inv");
      run_op(make_val(2,0,0), 0, 9'h011, 0, 1, 0, 6'd40, 6'd40, "R11 unc same index");

      // idle cycles (R12)
      @(negedge clk);
      op_value = '1; class_mask = 9'h1FF; qual_pred = 1'b1; unc_mode = 1'b1;
      dst_first = 6'd50; dst_second = 6'd51;
      repeat (3) @(negedge clk);
      check(pred_all === model, "R12 idle", pred_all, model);

      // random mix
      for (int i = 0; i < 400; i++) begin
         int          kind;
         logic [63:0] v;
         logic        nat, sn, unc, qp;
         logic [8:0]  m;
         logic [5:0]  a, b;
         string       tag;
         kind = int'($urandom_range(0, 5));
         v    = make_val(kind, 1'($urandom), {$urandom, $urandom});
         nat  = ($urandom_range(0, 7) == 0);
         m    = ($urandom_range(0, 9) == 0) ? 9'h1FF : 9'($urandom);
         sn   = 1'($urandom);
         unc  = 1'($urandom);
         qp   = ($urandom_range(0, 3) != 0);
         a    = 6'($urandom_range(0, 15));
         b    = 6'($urandom_range(0, 15));
         if (!qp && !unc)        tag = "R8 random";
         else if (!qp)           tag = "R9 random";
         else if (a == b)        tag = "R11 random";
         else if (a == 0 || b == 0) tag = "R2 random";
         else if (nat)           tag = "R5 random";
         else if (kind >= 4)     tag = "R4 random";
         else if (m == 9'h1FF)   tag = "R6 random";
         else if (sn)            tag = "R7 random";
         else                    tag = "R3 random";
         run_op(v, nat, m, sn, unc, qp, a, b, tag);
      end

      done = 1'b1;
      finish_run();
   end

endmodule